// File: doc/BRIEF.md
# Saturating Linear and Logarithmic Wiper Stepper

This block computes the next settings of a bank of digitally controlled resistor wipers. Each wiper holds a 10-bit code from 0 to 1023. A command selects one of four step operations:

- a linear step up by one;
- a linear step down by one;
- a doubling step, worth about +6 dB;
- a halving step, worth about −6 dB.

Every operation clamps at the ends of the code range instead of wrapping. A command acts on the one channel named by the channel select, or on all channels together when the gang flag is set.

The surrounding logic supplies the current wiper codes and pulses a one-cycle enable. One clock later the block presents the new codes and a one-cycle result strobe. The caller writes the new codes back into its wiper registers.

A write-protect input freezes every channel: the result then equals the current codes. The doubling step is shaped for a clean logarithmic sweep:

- a zero code moves to 1;
- any code at or above midscale goes straight to full scale.

A sequencing state machine has two states:

- `ST_IDLE`: no result is pending.
- `ST_EMIT`: a result is presented for one cycle.

It has three transitions:

- `T_ACCEPT`: from `ST_IDLE` to `ST_EMIT`, on an enable.
- `T_RETIRE`: from `ST_EMIT` to `ST_IDLE`, with no enable.
- `T_CHAIN`: from `ST_EMIT` to `ST_EMIT`, on a back-to-back enable.

Top module: `wstep_top`

## Requirements
- R1: After reset, `nxt_codes` is all zeros and `res_valid` is 0. An enable in one cycle makes `res_valid` high in the next cycle only. `nxt_codes` holds its value between enables.
- R2: Operation code 2'b00 adds one to an affected code. A code of 1023 stays 1023.
- R3: Operation code 2'b01 subtracts one from an affected code. A code of 0 stays 0.
- R4: Operation code 2'b10 works as follows on an affected code. Code 0 becomes 1. Codes 1 to 511 double. Codes 512 to 1023 become 1023.
- R5: Operation code 2'b11 shifts an affected code right by one bit. The least significant bit is dropped, so 0 stays 0.
- R6: With `gang` high, all channels are affected. With `gang` low, only the channel whose index equals `chan_sel` is affected. Every other channel's result equals its current code.
- R7: With `wp` high at the enable, every result equals the current code, whatever the operation.
- R8: Starting from 0, eleven successive doubling steps, each fed back as the next input, end at 1023.
- Code packing: channel k occupies bits [10k+9:10k] of `cur_codes` and `nxt_codes`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | One-cycle command enable |
| op | input | 2 | Operation: 00 up one, 01 down one, 10 double, 11 halve |
| chan_sel | input | SEL_W (1) | Channel affected when `gang` is low |
| gang | input | 1 | Apply to every channel |
| wp | input | 1 | Write protect; freezes all results |
| cur_codes | input | NCH*CODE_W (20) | Current wiper codes, channel 0 in the low bits |
| nxt_codes | output | NCH*CODE_W (20) | Registered next wiper codes |
| res_valid | output | 1 | One-cycle strobe marking new results |

## Verification
The bench builds the block with its defaults: two channels and 10-bit codes. With these values the two saturation ends (0 and 1023) and the midscale edge (511 against 512) are single directed commands. The full eleven-step logarithmic climb fits in a short feedback loop. Two channels are enough to show both that the selected channel changes and that the other channel is left alone, under single and ganged commands.

// File: rtl/wstep_pkg.sv
package wstep_pkg;
    typedef enum logic [1:0] {
        OP_INC = 2'b00,
        OP_DEC = 2'b01,
        OP_UP6 = 2'b10,
        OP_DN6 = 2'b11
    } step_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/wstep_lane.sv
module wstep_lane
    import wstep_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  step_op_e          op,
    input  logic              apply,
    input  logic [CODE_W-1:0] cur,
    output logic [CODE_W-1:0] nxt
);
    localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] MID  = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CODE_W-1:0] stepped;

    always_comb begin
        stepped = cur;
        unique case (op)
            OP_INC: stepped = (cur == FULL) ? FULL : cur + 1'b1;
            OP_DEC: stepped = (cur == '0) ? '0 : cur - 1'b1;
            OP_UP6: begin
                if (cur == '0)
                    stepped = {{(CODE_W-1){1'b0}}, 1'b1};
                else if (cur >= MID)
                    stepped = FULL;
                else
                    stepped = {cur[CODE_W-2:0], 1'b0};
            end
            OP_DN6: stepped = {1'b0, cur[CODE_W-1:1]};
        endcase
        nxt = apply ? stepped : cur;
    end
endmodule

// File: rtl/wstep_seq.sv
module wstep_seq
    import wstep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_en,
    output logic load,
    output logic res_valid
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (step_en) state_d = ST_EMIT;       // T_ACCEPT
            ST_EMIT: state_d = step_en ? ST_EMIT : ST_IDLE; // T_CHAIN / T_RETIRE
        endcase
    end

    always_comb begin
        load      = step_en;
        res_valid = (state_q == ST_EMIT);
    end
endmodule

// File: rtl/wstep_top.sv
module wstep_top
    import wstep_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int NCH    = 2,
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int BUS_W = NCH * CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic [1:0]       op,
    input  logic [SEL_W-1:0] chan_sel,
    input  logic             gang,
    input  logic             wp,
    input  logic [BUS_W-1:0] cur_codes,
    output logic [BUS_W-1:0] nxt_codes,
    output logic             res_valid
);
    localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] MID  = {1'b1, {(CODE_W-1){1'b0}}};

    logic             load;
    logic [BUS_W-1:0] lane_out;
    logic [BUS_W-1:0] nxt_q;
    step_op_e         op_e;

    assign op_e = step_op_e'(op);

    wstep_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .load     (load),
        .res_valid(res_valid)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
        logic hit;
        assign hit = !wp && (gang || (chan_sel == SEL_W'(ch)));
        wstep_lane #(.CODE_W(CODE_W)) u_lane (
            .op   (op_e),
            .apply(hit),
            .cur  (cur_codes[ch*CODE_W +: CODE_W]),
            .nxt  (lane_out[ch*CODE_W +: CODE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    nxt_q <= '0;
        else if (load) nxt_q <= lane_out;
    end

    assign nxt_codes = nxt_q;

    logic [CODE_W-1:0] cur0, nxt0;
    assign cur0 = cur_codes[CODE_W-1:0];
    assign nxt0 = nxt_codes[CODE_W-1:0];

    p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> res_valid);
    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> !res_valid && $stable(nxt_codes));
    p_inc_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && !wp && gang && op == 2'b00 && cur0 == FULL |=> nxt0 == FULL);
    p_dec_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && !wp && gang && op == 2'b01 && cur0 == '0 |=> nxt0 == '0);
    p_up6_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && !wp && gang && op == 2'b10 && cur0 >= MID |=> nxt0 == FULL);
    p_dn6_shrink_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && op == 2'b11 |=> nxt0 <= $past(cur0));
    p_unsel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && !gang && chan_sel != '0 |=> nxt0 == $past(cur0));
    p_wp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && wp |=> nxt_codes == $past(cur_codes));
endmodule

// File: tb/wstep_top_bench.sv
module wstep_top_bench;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_en = 1'b0;
    logic [1:0]    op = 2'b00;
    logic [0:0]    chan_sel = 1'b0;
    logic          gang = 1'b0;
    logic          wp = 1'b0;
    logic [2*CW-1:0] cur_codes = '0;
    logic [2*CW-1:0] nxt_codes;
    logic          res_valid;

    int total = 0;
    int bad = 0;
    bit mon_on = 1'b0;

    typedef struct {
        logic [CW-1:0] e0;
        logic [CW-1:0] e1;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    wstep_top u_wstep_top (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .op(op),
        .chan_sel(chan_sel), .gang(gang), .wp(wp),
        .cur_codes(cur_codes), .nxt_codes(nxt_codes), .res_valid(res_valid)
    );

    function automatic logic [CW-1:0] model(input logic [1:0] o, input logic [CW-1:0] c);
        int v;
        v = int'(c);
        case (o)
            2'b00: v = (v == 1023) ? 1023 : v + 1;
            2'b01: v = (v == 0) ? 0 : v - 1;
            2'b10: v = (v == 0) ? 1 : ((v >= 512) ? 1023 : v * 2);
            default: v = v / 2;
        endcase
        return CW'(v);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_step(input logic [1:0] o, input logic s, input logic g,
                           input logic w, input int c0, input int c1, input string tag);
        exp_t e;
        logic [CW-1:0] a0, a1;
        a0 = CW'(c0);
        a1 = CW'(c1);
        e.e0 = (!w && (g || s == 1'b0)) ? model(o, a0) : a0;
        e.e1 = (!w && (g || s == 1'b1)) ? model(o, a1) : a1;
        e.tag = tag;
        @(negedge clk);
        op = o; chan_sel = s; gang = g; wp = w;
        cur_codes = {a1, a0};
        step_en = 1'b1;
        sb.push_back(e);
        @(negedge clk);
        step_en = 1'b0;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (mon_on && res_valid) begin
                if (sb.size() == 0) begin
                    check("R1 unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " ch0"}, int'(nxt_codes[CW-1:0]), int'(e.e0));
                    check({e.tag, " ch1"}, int'(nxt_codes[2*CW-1:CW]), int'(e.e1));
                end
            end
        end
    end

    initial begin : watchdog
        #(4 * 100000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [CW-1:0] x;
        repeat (3) @(negedge clk);
        check("R1 reset codes", int'(nxt_codes), 0);
        check("R1 reset strobe", int'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        // R1: strobe exactly one cycle after enable, then low
        do_step(2'b00, 1'b0, 1'b1, 1'b0, 5, 9, "R1 timing");
        check("R1 strobe at +1", int'(res_valid), 1);
        @(negedge clk);
        check("R1 strobe drops", int'(res_valid), 0);
        check("R1 hold codes", int'(nxt_codes), int'({10'd10, 10'd6}));

        // R2 increment
        do_step(2'b00, 1'b0, 1'b1, 1'b0, 1023, 1022, "R2 inc saturate");
        do_step(2'b00, 1'b1, 1'b0, 1'b0, 0, 511, "R2 inc ch1");
        // R3 decrement
        do_step(2'b01, 1'b0, 1'b1, 1'b0, 0, 7, "R3 dec floor");
        do_step(2'b01, 1'b0, 1'b0, 1'b0, 1, 1023, "R3 dec ch0");
        // R4 doubling step
        do_step(2'b10, 1'b0, 1'b1, 1'b0, 0, 300, "R4 up6 zero/mid");
        do_step(2'b10, 1'b0, 1'b1, 1'b0, 511, 512, "R4 up6 midscale edge");
        do_step(2'b10, 1'b0, 1'b1, 1'b0, 1023, 1, "R4 up6 full/one");
        // R5 halving step
        do_step(2'b11, 1'b0, 1'b1, 1'b0, 5, 1, "R5 dn6 odd");
        do_step(2'b11, 1'b0, 1'b1, 1'b0, 0, 1023, "R5 dn6 zero/full");
        // R6 selection
        do_step(2'b00, 1'b1, 1'b0, 1'b0, 100, 200, "R6 sel ch1 only");
        do_step(2'b01, 1'b0, 1'b0, 1'b0, 100, 200, "R6 sel ch0 only");
        do_step(2'b11, 1'b1, 1'b1, 1'b0, 100, 200, "R6 gang both");
        // R7 write protect
        do_step(2'b00, 1'b0, 1'b1, 1'b1, 42, 1023, "R7 wp inc");
        do_step(2'b10, 1'b1, 1'b0, 1'b1, 0, 300, "R7 wp up6");

        // R8 eleven doubling steps fed back
        x = '0;
        for (int i = 0; i < 11; i++) begin
            do_step(2'b10, 1'b0, 1'b0, 1'b0, int'(x), 3, "R8 chain step");
            x = nxt_codes[CW-1:0];
        end
        check("R8 eleven steps reach full", int'(x), 1023);

        repeat (3) @(negedge clk);
        check("R1 no pending results", sb.size(), 0);
        check("R1 idle strobe low", int'(res_valid), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule